// File: doc/BRIEF.md
# Two-Queue Two-Core Instruction Dispatcher

This block sits between two instruction queues and two execution cores. A fetch engine places instruction words into a small buffer per queue, and the dispatcher hands each buffered word to a core. A core receives a word only when it is idle and the queue may feed it. Each queue has an enable bit and a two-bit core mask. A two-bit priority code picks the order in which the queues are served: fixed priority for queue 0, fixed priority for queue 1, or round robin.

For each core the block keeps a registered view of its work. This view holds a busy flag, the queue the current or last word came from, and that word's instruction index. The index counts the words dispatched from that queue since reset. The view also holds a count of the words the core has completed. A core reports completion with a one-cycle done pulse and only then becomes eligible for another word.

Top module: `queue_core_dispatch`

## Requirements
- R1: After synchronous reset, every core shows busy 0, start 0, queue ID 0, index 0 and completed count 0, and `fill_ready` equals `q_enable`.
- R2: `fill_ready[q]` is 1 exactly when queue q is enabled and its buffer holds fewer than FIFO_DEPTH words. A fill offered to a disabled queue is not stored.
- R3: Bit 2q+c of `q_core_mask` allows queue q to feed core c, and a word from queue q never starts on a core whose bit is 0. A queue with mask 00 still accepts fills but dispatches nothing.
- R4: A disabled queue dispatches nothing, even when its buffer holds words.
- R5: When a core is idle and an allowed enabled queue holds a word during a cycle, the following clock edge raises that core's `core_start` for one cycle and sets busy. The same edge loads the word's data and its queue ID. Words from one queue leave in the order they were filled.
- R6: The index given with a word equals the number of words dispatched from the same queue before it since reset, counting from 0.
- R7: A done pulse on a busy core clears busy and adds one to its completed count at the next edge, and no new start comes on that same edge. A done pulse on an idle core changes nothing.
- R8: When both cores are idle, core 0 chooses first. Core 1 takes only a different queue in that cycle, so one queue feeds at most one core per cycle.
- R9: Priority code 01 serves queue 0 first and code 10 serves queue 1 first whenever both queues could feed a core.
- R10: Priority codes 00 and 11 give round robin. After a grant, the other queue is favored. When both cores are granted in one cycle, core 1's grant counts as the later one. The pointer resets to favor queue 0.
- R11: The two cores may start on the same edge with words from the two different queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_enable | input | 2 | Enable per queue |
| q_core_mask | input | 4 | Bits [2q+1:2q] are queue q's allowed cores, with the low bit for core 0 |
| prio_mode | input | 2 | 01 favors queue 0, 10 favors queue 1, 00 and 11 select round robin |
| fill_valid | input | 2 | Fetch offers a word to queue q |
| fill_data | input | 2*DATA_W | Slice q holds the word offered to queue q |
| fill_ready | output | 2 | Queue q accepts its offered word this cycle |
| core_done | input | 2 | Core c finished its current word |
| core_start | output | 2 | One-cycle pulse when core c receives a word |
| core_data | output | 2*DATA_W | Word held by core c |
| core_busy | output | 2 | Core c is executing |
| core_qid | output | 2 | Queue of core c's current or last word |
| core_idx | output | 2*IDX_W | Instruction index of core c's current or last word |
| core_count | output | 2*CNT_W | Words completed by core c |

## Verification
A fill accepted on one edge can be dispatched on the next edge, and its start and data then show for one cycle. A done pulse sampled on an edge clears busy right after that edge, and a waiting word starts one edge later. The bench drives inputs and reads outputs on the falling edge, so each result is read in the half cycle after the edge that produced it. Dispatches are compared against per-core expected lists whose queue, index and data come from the requirements, and any start with no pending expectation counts as a mismatch.

// File: rtl/disp_pkg.sv
package disp_pkg;

  localparam logic [1:0] PRIO_FAVOR_Q0 = 2'b01;
  localparam logic [1:0] PRIO_FAVOR_Q1 = 2'b10;

  // Choose a queue among the candidates; favored queue wins when it is a candidate.
  function automatic logic pick_queue(input logic [1:0] cand,
                                      input logic [1:0] mode,
                                      input logic       rr_fav);
    logic fav;
    if (mode == PRIO_FAVOR_Q0)      fav = 1'b0;
    else if (mode == PRIO_FAVOR_Q1) fav = 1'b1;
    else                            fav = rr_fav;
    return cand[fav] ? fav : ~fav;
  endfunction

endpackage

// File: rtl/disp_fifo.sv
module disp_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;

  // storage without reset so that a RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == FULLC);

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full); // R2
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R5

endmodule

// File: rtl/disp_arbiter.sv
module disp_arbiter
  import disp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] avail,
  input  logic [3:0] mask,
  input  logic [1:0] mode,
  input  logic [1:0] core_idle,
  output logic [1:0] gnt_vld,
  output logic [1:0] gnt_q
);
  logic       rr_fav;
  logic [1:0] cand0, cand1, taken;

  always_comb begin
    cand0      = {avail[1] & mask[2], avail[0] & mask[0]} & {2{core_idle[0]}};
    gnt_vld[0] = |cand0;
    gnt_q[0]   = pick_queue(cand0, mode, rr_fav);
    taken      = gnt_vld[0] ? (gnt_q[0] ? 2'b10 : 2'b01) : 2'b00;
    cand1      = {avail[1] & mask[3], avail[0] & mask[1]} & {2{core_idle[1]}} & ~taken;
    gnt_vld[1] = |cand1;
    gnt_q[1]   = pick_queue(cand1, mode, rr_fav);
  end

  // pointer moves past the queue granted last; core 1 counts as later
  always_ff @(posedge clk) begin
    if (rst)             rr_fav <= 1'b0;
    else if (gnt_vld[1]) rr_fav <= ~gnt_q[1];
    else if (gnt_vld[0]) rr_fav <= ~gnt_q[0];
  end

  AST_ONE_QUEUE_ONE_CORE: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld[0] && gnt_vld[1]) |-> (gnt_q[0] != gnt_q[1])); // R8

endmodule

// File: rtl/disp_core_track.sv
module disp_core_track #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              grant_q,
  input  logic [IDX_W-1:0]  grant_idx,
  input  logic [DATA_W-1:0] grant_data,
  input  logic              done,
  output logic              busy,
  output logic              start,
  output logic              qid,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      start <= 1'b0;
      qid   <= 1'b0;
      idx   <= '0;
      data  <= '0;
      count <= '0;
    end else begin
      start <= 1'b0;
      if (grant) begin
        busy  <= 1'b1;
        start <= 1'b1;
        qid   <= grant_q;
        idx   <= grant_idx;
        data  <= grant_data;
      end else if (done && busy) begin
        busy  <= 1'b0;
        count <= count + 1'b1;
      end
    end
  end

  AST_GRANT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst) grant |-> !busy); // R7
  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (done && busy) |=> (!busy && !start && count == $past(count) + 1'b1)); // R7
  AST_IDLE_DONE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (done && !busy && !grant) |=> $stable(count)); // R7
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst) start |-> busy); // R5

endmodule

// File: rtl/queue_core_dispatch.sv
module queue_core_dispatch #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int IDX_W      = 32,
  parameter int CNT_W      = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          q_enable,
  input  logic [3:0]          q_core_mask,
  input  logic [1:0]          prio_mode,
  input  logic [1:0]          fill_valid,
  input  logic [2*DATA_W-1:0] fill_data,
  output logic [1:0]          fill_ready,
  input  logic [1:0]          core_done,
  output logic [1:0]          core_start,
  output logic [2*DATA_W-1:0] core_data,
  output logic [1:0]          core_busy,
  output logic [1:0]          core_qid,
  output logic [2*IDX_W-1:0]  core_idx,
  output logic [2*CNT_W-1:0]  core_count
);
  localparam int NQ = 2;
  localparam int NC = 2;

  logic [NQ-1:0]     q_empty, q_full, q_pop, q_avail;
  logic [DATA_W-1:0] q_head [NQ];
  logic [IDX_W-1:0]  q_issued [NQ];
  logic [NC-1:0]     g_vld, g_q;

  assign fill_ready = q_enable & ~q_full;
  assign q_avail    = q_enable & ~q_empty;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    assign q_pop[q] = (g_vld[0] && (g_q[0] == 1'(q))) || (g_vld[1] && (g_q[1] == 1'(q)));

    disp_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (fill_valid[q] & fill_ready[q]),
      .wr_data (fill_data[q*DATA_W +: DATA_W]),
      .rd_en   (q_pop[q]),
      .rd_data (q_head[q]),
      .empty   (q_empty[q]),
      .full    (q_full[q])
    );

    always_ff @(posedge clk) begin
      if (rst)           q_issued[q] <= '0;
      else if (q_pop[q]) q_issued[q] <= q_issued[q] + 1'b1;
    end
  end

  disp_arbiter i_arb (
    .clk       (clk),
    .rst       (rst),
    .avail     (q_avail),
    .mask      (q_core_mask),
    .mode      (prio_mode),
    .core_idle (~core_busy),
    .gnt_vld   (g_vld),
    .gnt_q     (g_q)
  );

  for (genvar c = 0; c < NC; c++) begin : g_core
    disp_core_track #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_trk (
      .clk        (clk),
      .rst        (rst),
      .grant      (g_vld[c]),
      .grant_q    (g_q[c]),
      .grant_idx  (q_issued[g_q[c]]),
      .grant_data (q_head[g_q[c]]),
      .done       (core_done[c]),
      .busy       (core_busy[c]),
      .start      (core_start[c]),
      .qid        (core_qid[c]),
      .idx        (core_idx[c*IDX_W +: IDX_W]),
      .data       (core_data[c*DATA_W +: DATA_W]),
      .count      (core_count[c*CNT_W +: CNT_W])
    );

    AST_GRANT_MASKED: assert property (@(posedge clk) disable iff (rst)
      g_vld[c] |-> q_core_mask[{g_q[c], 1'(c)}]); // R3
    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (rst)
      g_vld[c] |-> q_enable[g_q[c]]); // R4
  end

endmodule

// File: tb/test_queue_core_dispatch.sv
module test_queue_core_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int IW = 32;
  localparam int CW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] q_enable = 2'b11;
  logic [3:0] q_core_mask = 4'h0;
  logic [1:0] prio_mode = 2'b01;
  logic [1:0] fill_valid = 2'b00;
  logic [2*DW-1:0] fill_data = '0;
  logic [1:0] fill_ready;
  logic [1:0] core_done = 2'b00;
  logic [1:0] core_start, core_busy, core_qid;
  logic [2*DW-1:0] core_data;
  logic [2*IW-1:0] core_idx;
  logic [2*CW-1:0] core_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  queue_core_dispatch #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .IDX_W(IW), .CNT_W(CW)) i_queue_core_dispatch (
    .clk(clk), .rst(rst), .q_enable(q_enable), .q_core_mask(q_core_mask),
    .prio_mode(prio_mode), .fill_valid(fill_valid), .fill_data(fill_data),
    .fill_ready(fill_ready), .core_done(core_done), .core_start(core_start),
    .core_data(core_data), .core_busy(core_busy), .core_qid(core_qid),
    .core_idx(core_idx), .core_count(core_count));

  int n_cmp = 0;
  int n_bad = 0;
  logic [48:0] exp0[$];
  logic [48:0] exp1[$];
  int q_seq [2] = '{0, 0};
  int exp_cnt [2] = '{0, 0};

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // expected item: {qid, index, data}; index per queue counted here (R6)
  task automatic expect_disp(input int c, input int q, input logic [DW-1:0] d);
    logic [48:0] it;
    it = {1'(q), 32'(q_seq[q]), d};
    q_seq[q]++;
    if (c == 0) exp0.push_back(it); else exp1.push_back(it);
  endtask

  task automatic fill(input int q, input logic [DW-1:0] d);
    fill_valid[q] = 1'b1;
    fill_data[q*DW +: DW] = d;
    @(negedge clk);
    fill_valid[q] = 1'b0;
  endtask

  task automatic pulse_done(input int c, input bit counts);
    core_done[c] = 1'b1;
    @(negedge clk);
    core_done[c] = 1'b0;
    if (counts) exp_cnt[c]++;
  endtask

  // monitor: compare each start against the scoreboard (R5, R6)
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 2; c++) begin
        if (core_start[c]) begin
          logic [48:0] got, want;
          got = {core_qid[c], core_idx[c*IW +: IW], core_data[c*DW +: DW]};
          if ((c == 0 && exp0.size() == 0) || (c == 1 && exp1.size() == 0)) begin
            n_cmp++; n_bad++;
            $display("FAIL R3/R4 unexpected start core%0d actual=%0h expected=none", c, got);
          end else begin
            want = (c == 0) ? exp0.pop_front() : exp1.pop_front();
            chk(got == want, $sformatf("R5/R6 dispatch core%0d", c), longint'(got), longint'(want));
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk(core_busy == 0 && core_start == 0 && core_qid == 0, "R1 busy/start/qid", core_busy, 0);
    chk(core_idx == 0 && core_count == 0, "R1 idx/count", core_count, 0);
    chk(fill_ready == 2'b11, "R1 fill_ready", fill_ready, 2'b11);

    // preload with mask 00: accepted but not dispatched (R3)
    fill(0, 16'hA000); fill(0, 16'hA001); fill(1, 16'hB000); fill(1, 16'hB001);
    repeat (4) @(negedge clk);
    chk(core_busy == 0, "R3 zero mask holds", core_busy, 0);

    // fixed priority queue 0, both cores idle (R8, R9, R11)
    expect_disp(0, 0, 16'hA000); expect_disp(1, 1, 16'hB000);
    expect_disp(0, 0, 16'hA001); expect_disp(1, 1, 16'hB001);
    q_core_mask = 4'hF;
    @(negedge clk);
    chk(core_start == 2'b11, "R11 simultaneous start", core_start, 2'b11);
    @(negedge clk);
    chk(core_start == 2'b00 && core_busy == 2'b11, "R5 start pulse one cycle", core_start, 0);
    pulse_done(0, 1);
    chk(core_busy[0] == 1'b0 && core_start[0] == 1'b0, "R7 busy clears, no same-edge start", core_busy, 2'b10);
    @(negedge clk);
    chk(core_start[0] == 1'b1, "R7 next start one edge later", core_start, 2'b01);
    pulse_done(1, 1);
    @(negedge clk);
    pulse_done(0, 1); pulse_done(1, 1);
    pulse_done(0, 0);
    @(negedge clk);
    chk(core_count[0 +: CW] == 32'(exp_cnt[0]), "R7 idle done ignored", core_count[0 +: CW], exp_cnt[0]);

    // fixed priority queue 1, core 0 only (R9)
    q_core_mask = 4'h0;
    fill(0, 16'hC000); fill(1, 16'hD000);
    expect_disp(0, 1, 16'hD000); expect_disp(0, 0, 16'hC000);
    prio_mode = 2'b10; q_core_mask = 4'b0101;
    repeat (2) @(negedge clk);
    chk(core_qid[0] == 1'b1, "R9 queue 1 first", core_qid[0], 1);
    pulse_done(0, 1);
    repeat (2) @(negedge clk);
    pulse_done(0, 1);

    // round robin, pointer favors queue 1 after last grant to queue 0 (R10)
    q_core_mask = 4'h0;
    fill(0, 16'hE000); fill(0, 16'hE001); fill(1, 16'hF000); fill(1, 16'hF001);
    expect_disp(0, 1, 16'hF000); expect_disp(0, 0, 16'hE000);
    expect_disp(0, 1, 16'hF001); expect_disp(0, 0, 16'hE001);
    prio_mode = 2'b00; q_core_mask = 4'b0101;
    for (int k = 0; k < 4; k++) begin
      repeat (2) @(negedge clk);
      chk(core_qid[0] == 1'(k % 2 == 0), "R10 round robin alternation", core_qid[0], (k % 2 == 0));
      pulse_done(0, 1);
    end

    // queue 1 allowed only on core 1 (R3)
    q_core_mask = 4'h0;
    fill(1, 16'h6000);
    expect_disp(1, 1, 16'h6000);
    q_core_mask = 4'b1000;
    repeat (3) @(negedge clk);
    chk(core_busy == 2'b10, "R3 only core 1 served", core_busy, 2'b10);
    pulse_done(1, 1);

    // full buffer and disabled queue (R2, R4)
    q_core_mask = 4'h0;
    for (int k = 0; k < DEPTH; k++) fill(0, 16'h7000 + 16'(k));
    chk(fill_ready[0] == 1'b0, "R2 full buffer not ready", fill_ready[0], 0);
    q_enable = 2'b10; q_core_mask = 4'hF; prio_mode = 2'b11;
    repeat (5) @(negedge clk);
    chk(core_busy == 2'b00, "R4 disabled queue not dispatched", core_busy, 0);
    chk(fill_ready[0] == 1'b0, "R2 disabled not ready", fill_ready[0], 0);

    // both idle, one queue: core 0 first, core 1 next cycle (R8)
    expect_disp(0, 0, 16'h7000); expect_disp(1, 0, 16'h7001);
    expect_disp(0, 0, 16'h7002); expect_disp(1, 0, 16'h7003);
    q_enable = 2'b11;
    @(negedge clk);
    chk(core_busy == 2'b01, "R8 core 0 chooses first", core_busy, 2'b01);
    @(negedge clk);
    chk(core_busy == 2'b11, "R8 core 1 next cycle", core_busy, 2'b11);
    pulse_done(0, 1); @(negedge clk);
    pulse_done(1, 1); @(negedge clk);
    pulse_done(0, 1); pulse_done(1, 1);

    // fill offered to disabled queue is dropped (R2)
    q_enable = 2'b10;
    fill(0, 16'hDEAD);
    q_enable = 2'b11;
    repeat (5) @(negedge clk);
    chk(core_busy == 2'b00, "R2 disabled fill dropped", core_busy, 0);

    chk(exp0.size() == 0 && exp1.size() == 0, "R5 all expected dispatched", exp0.size() + exp1.size(), 0);
    chk(core_count[0 +: CW] == 32'(exp_cnt[0]), "R7 core 0 count", core_count[0 +: CW], exp_cnt[0]);
    chk(core_count[CW +: CW] == 32'(exp_cnt[1]), "R7 core 1 count", core_count[CW +: CW], exp_cnt[1]);
    chk(core_idx[IW +: IW] == 32'd8, "R6 last index core 1", core_idx[IW +: IW], 8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule